// File: doc/BRIEF.md
# Chained Descriptor Loader

This block walks a circular chain of transfer configurations held in memory and loads each one into a channel's registers. A start strobe captures a head pointer. The loader then reads the first descriptor one word at a time through a valid/ready read port and loads the channel. It waits for the data mover to report that the transfer is finished, then follows the descriptor's next pointer to the following configuration. The last descriptor points back to the head. The loader detects that return, pulses a completion flag and goes idle.

While a transfer runs, the block also generates transfer addresses. Each beat reported by the data mover advances the address by one word. When the address equals the descriptor's wrap boundary, the next address is the descriptor's wrap-to value instead. The block does not move any data.

A descriptor is four address-wide words at consecutive word addresses:
- word 0: start address
- word 1: wrap boundary
- word 2: wrap-to value
- word 3: next pointer

Read port rules:
- A request stays valid with a stable address until `rd_req_ready` is seen high.
- Only one read is outstanding at a time.
- `rd_rsp_ready` is high only while the loader waits for the response of an accepted request.
- The memory may hold its response back for as long as it needs.

Top module: `dll_loader`

## Requirements
- R1: After reset, `busy`, `err`, `list_done`, `ch_load`, `rd_req_valid` and `rd_rsp_ready` are all 0.
- R2: When start is accepted with an aligned head pointer, the loader reads four words at the head pointer plus 0, 4, 8 and 12, in that order. Each request is held valid with a stable address until it is accepted.
- R3: On the second clock edge after the fourth word's response is accepted, `ch_load` goes high for exactly one cycle. At that point `ch_addr`, `ch_wrap_at` and `ch_wrap_to` hold words 0, 1 and 2 of the descriptor.
- R4: While a transfer runs, a `beat` changes `ch_addr` on the next clock edge. It becomes `ch_wrap_to` if `ch_addr` equals `ch_wrap_at`, and `ch_addr + 4` otherwise. Without a beat, `ch_addr` changes only on a load.
- R5: On `xfer_done`, if the next pointer (word 3) differs from the head pointer, the loader fetches the descriptor at the next pointer and loads it.
- R6: On `xfer_done`, if the next pointer equals the head pointer, `list_done` is high for one cycle after that edge. `busy` falls on the following edge, and no further read is issued.
- R7: A start strobe while `busy` is high is ignored: no read is issued and the chain being walked is unchanged.
- R8: A response with `rd_rsp_err` high aborts the chain. `err` goes to 1 and `busy` to 0, and there is no load and no `list_done`. The next accepted start clears `err`.
- R9: A pointer whose two low bits are not zero is unaligned and aborts the chain with `err` set. An unaligned head pointer is rejected at start with no memory read. An unaligned next pointer is rejected after its descriptor is read, with no load.
- R10: `rd_rsp_ready` is high only while a read request has been accepted and its response is pending, and never together with `rd_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking the chain at `head_ptr` (ignored while busy) |
| head_ptr | input | AW | Address of the first descriptor |
| busy | output | 1 | Loader is not idle |
| err | output | 1 | Chain aborted by a read error or an unaligned pointer |
| list_done | output | 1 | One-cycle pulse when the chain returns to its head |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | AW | Word address of the read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Loader accepts the response |
| rd_rsp_data | input | AW | Read data |
| rd_rsp_err | input | 1 | Read response carries an error |
| ch_load | output | 1 | One-cycle pulse when channel registers take a new descriptor |
| ch_addr | output | AW | Current transfer address |
| ch_wrap_at | output | AW | Wrap boundary of the loaded descriptor |
| ch_wrap_to | output | AW | Wrap-to value of the loaded descriptor |
| beat | input | 1 | Data mover finished one word at `ch_addr` |
| xfer_done | input | 1 | Data mover finished the current transfer |

## Verification
The latencies are fixed:
- The first read request is valid one edge after start is accepted.
- `ch_load` appears two edges after the final word's response is accepted.
- An address step is visible one edge after its beat.
- `list_done` is high one edge after `xfer_done`, and `busy` drops one edge after that.
- `err` is set one edge after the aborting response or the rejected start.

The bench drives every input on the falling edge. It samples each output on a later falling edge, at the exact count of edges given above. For the read sequence, it waits for the `ch_load` pulse and then compares the logged request addresses.

// File: rtl/dll_pkg.sv
package dll_pkg;
  localparam int DESC_WORDS = 4;
  localparam int W_XADDR    = 0;
  localparam int W_WRAP_AT  = 1;
  localparam int W_WRAP_TO  = 2;
  localparam int W_NEXT     = DESC_WORDS - 1;

  typedef enum logic [2:0] {
    LDR_IDLE,
    LDR_FETCH,
    LDR_LOAD,
    LDR_RUN,
    LDR_DONE
  } ldr_state_e;
endpackage

// File: rtl/dll_desc_buf.sv
module dll_desc_buf #(
  parameter int AW    = 32,
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [AW-1:0]            wr_data,
  output logic [WORDS-1:0][AW-1:0] words
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr_en && (wr_idx == g[$clog2(WORDS)-1:0]))
        words[g] <= wr_data;
    end
  end
endmodule

// File: rtl/dll_addr_gen.sv
module dll_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [AW-1:0] load_wrap_at,
  input  logic [AW-1:0] load_wrap_to,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wrap_at,
  output logic [AW-1:0] wrap_to
);
  localparam logic [AW-1:0] STEP_V = AW'(AW / 8);

  logic [AW-1:0] addr_nxt;
  assign addr_nxt = (addr == wrap_at) ? wrap_to : addr + STEP_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      wrap_at <= '0;
      wrap_to <= '0;
    end else if (load) begin
      addr    <= load_addr;
      wrap_at <= load_wrap_at;
      wrap_to <= load_wrap_to;
    end else if (step) begin
      addr    <= addr_nxt;
    end
  end
endmodule

// File: rtl/dll_loader.sv
module dll_loader #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] head_ptr,
  output logic          busy,
  output logic          err,
  output logic          list_done,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [AW-1:0] rd_rsp_data,
  input  logic          rd_rsp_err,
  output logic          ch_load,
  output logic [AW-1:0] ch_addr,
  output logic [AW-1:0] ch_wrap_at,
  output logic [AW-1:0] ch_wrap_to,
  input  logic          beat,
  input  logic          xfer_done
);
  import dll_pkg::*;

  localparam int ALIGN = $clog2(AW / 8);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  ldr_state_e                     st;
  logic [AW-1:0]                  head_q;
  logic [AW-1:0]                  cur_q;
  logic [IDX_W-1:0]               idx_q;
  logic                           wait_q;
  logic                           err_q;
  logic                           load_q;
  logic [DESC_WORDS-1:0][AW-1:0]  words;
  logic                           rsp_fire;
  logic                           next_ok;
  logic                           do_load;

  function automatic logic misaligned(input logic [AW-1:0] p);
    return |p[ALIGN-1:0];
  endfunction

  assign rsp_fire     = rd_rsp_valid && rd_rsp_ready;
  assign rd_req_valid = (st == LDR_FETCH) && !wait_q;
  assign rd_rsp_ready = (st == LDR_FETCH) && wait_q;
  assign rd_req_addr  = cur_q + {{(AW-IDX_W-ALIGN){1'b0}}, idx_q, {ALIGN{1'b0}}};
  assign next_ok      = !misaligned(words[W_NEXT]);
  assign do_load      = (st == LDR_LOAD) && next_ok;
  assign busy         = (st != LDR_IDLE);
  assign err          = err_q;
  assign list_done    = (st == LDR_DONE);
  assign ch_load      = load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LDR_IDLE;
      head_q <= '0;
      cur_q  <= '0;
      idx_q  <= '0;
      wait_q <= 1'b0;
      err_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      unique case (st)
        LDR_IDLE: begin
          if (start) begin
            if (misaligned(head_ptr)) begin
              err_q <= 1'b1;
            end else begin
              err_q  <= 1'b0;
              head_q <= head_ptr;
              cur_q  <= head_ptr;
              idx_q  <= '0;
              wait_q <= 1'b0;
              st     <= LDR_FETCH;
            end
          end
        end
        LDR_FETCH: begin
          if (rd_req_valid && rd_req_ready)
            wait_q <= 1'b1;
          if (rsp_fire) begin
            if (rd_rsp_err) begin
              err_q <= 1'b1;
              st    <= LDR_IDLE;
            end else if (idx_q == IDX_LAST) begin
              st <= LDR_LOAD;
            end else begin
              idx_q  <= idx_q + 1'b1;
              wait_q <= 1'b0;
            end
          end
        end
        LDR_LOAD: begin
          if (next_ok) begin
            load_q <= 1'b1;
            st     <= LDR_RUN;
          end else begin
            err_q <= 1'b1;
            st    <= LDR_IDLE;
          end
        end
        LDR_RUN: begin
          if (xfer_done) begin
            if (words[W_NEXT] == head_q) begin
              st <= LDR_DONE;
            end else begin
              cur_q  <= words[W_NEXT];
              idx_q  <= '0;
              wait_q <= 1'b0;
              st     <= LDR_FETCH;
            end
          end
        end
        LDR_DONE: st <= LDR_IDLE;
        default:  st <= LDR_IDLE;
      endcase
    end
  end

  dll_desc_buf #(.AW(AW), .WORDS(DESC_WORDS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rsp_fire && !rd_rsp_err && (st == LDR_FETCH)),
    .wr_idx  (idx_q),
    .wr_data (rd_rsp_data),
    .words   (words)
  );

  dll_addr_gen #(.AW(AW)) u_agen (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (do_load),
    .load_addr    (words[W_XADDR]),
    .load_wrap_at (words[W_WRAP_AT]),
    .load_wrap_to (words[W_WRAP_TO]),
    .step         ((st == LDR_RUN) && beat),
    .addr         (ch_addr),
    .wrap_at      (ch_wrap_at),
    .wrap_to      (ch_wrap_to)
  );
endmodule

// File: rtl/dll_loader_chk.sv
module dll_loader_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          list_done,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          rd_rsp_ready,
  input logic          ch_load,
  input logic [AW-1:0] ch_addr,
  input logic [AW-1:0] ch_wrap_at,
  input logic [AW-1:0] ch_wrap_to,
  input logic          beat,
  input logic          in_run
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !rd_rsp_ready && !list_done));

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r3_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ch_load |=> !ch_load);

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && beat && (ch_addr == ch_wrap_at)) |=> (ch_addr == $past(ch_wrap_to)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_run && beat) |=> (ch_load || $stable(ch_addr)));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> (!busy && !list_done));

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid);
endmodule

bind dll_loader dll_loader_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .list_done    (list_done),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_ready (rd_rsp_ready),
  .ch_load      (ch_load),
  .ch_addr      (ch_addr),
  .ch_wrap_at   (ch_wrap_at),
  .ch_wrap_to   (ch_wrap_to),
  .beat         (beat),
  .in_run       (st == dll_pkg::LDR_RUN)
);

// File: tb/sim_dll_loader.sv
module sim_dll_loader;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [AW-1:0] head_ptr = '0;
  logic busy, err, list_done, rd_req_valid, rd_rsp_ready, ch_load;
  logic rd_req_ready = 1'b1;
  logic rd_rsp_valid = 1'b0;
  logic rd_rsp_err = 1'b0;
  logic [AW-1:0] rd_rsp_data = '0;
  logic [AW-1:0] rd_req_addr, ch_addr, ch_wrap_at, ch_wrap_to;
  logic beat = 0;
  logic xfer_done = 0;

  logic bp_en = 0;
  logic [AW-1:0] err_addr = 32'hFFFF_FFFF;
  logic [AW-1:0] mem [0:63];
  logic [AW-1:0] log_a [0:255];
  int log_n = 0;
  int load_n = 0;
  int done_n = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_loader #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr),
    .busy(busy), .err(err), .list_done(list_done),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err), .ch_load(ch_load), .ch_addr(ch_addr),
    .ch_wrap_at(ch_wrap_at), .ch_wrap_to(ch_wrap_to), .beat(beat), .xfer_done(xfer_done)
  );

  // memory model: one cycle response after an accepted request
  always @(posedge clk) begin
    rd_req_ready <= bp_en ? ~rd_req_ready : 1'b1;
    if (rd_rsp_valid && rd_rsp_ready) rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_req_addr[7:2]];
      rd_rsp_err   <= (rd_req_addr == err_addr);
      log_a[log_n[7:0]] <= rd_req_addr;
      log_n <= log_n + 1;
    end
    if (ch_load) load_n <= load_n + 1;
    if (list_done) done_n <= done_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic put_desc(input logic [AW-1:0] base, input logic [AW-1:0] a,
                          input logic [AW-1:0] wa, input logic [AW-1:0] wt, input logic [AW-1:0] nx);
    mem[base[7:2]]     = a;
    mem[base[7:2] + 1] = wa;
    mem[base[7:2] + 2] = wt;
    mem[base[7:2] + 3] = nx;
  endtask

  task automatic do_start(input logic [AW-1:0] p);
    @(negedge clk); head_ptr = p; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_load(input string tag);
    int k = 0;
    while (!ch_load && k < 200) begin @(negedge clk); k++; end
    chk(ch_load, tag, {31'd0, ch_load}, 1);
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic do_beat(input logic [AW-1:0] exp, input string tag);
    beat = 1; @(negedge clk); beat = 0;
    chk(ch_addr == exp, tag, ch_addr, exp);
  endtask

  task automatic pulse_done();
    xfer_done = 1; @(negedge clk); xfer_done = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !err && !list_done && !ch_load, "R1 status idle",
        {28'd0, busy, err, list_done, ch_load}, 0);
    chk(!rd_req_valid && !rd_rsp_ready, "R1 read port quiet",
        {30'd0, rd_req_valid, rd_rsp_ready}, 0);
  endtask

  task automatic t_single();
    int b = log_n;
    put_desc(32'h40, 32'h100, 32'h108, 32'h100, 32'h40);
    do_start(32'h40);
    wait_load("R3 load pulse seen");
    chk(log_n - b == 4, "R2 four reads", log_n - b, 4);
    for (int i = 0; i < 4; i++)
      chk(log_a[b + i] == 32'h40 + 4 * i, "R2 read order", log_a[b + i], 32'h40 + 4 * i);
    chk(ch_addr == 32'h100, "R3 ch_addr", ch_addr, 32'h100);
    chk(ch_wrap_at == 32'h108 && ch_wrap_to == 32'h100, "R3 wrap regs", ch_wrap_at, 32'h108);
    @(negedge clk);
    chk(!ch_load, "R3 one-cycle pulse", {31'd0, ch_load}, 0);
    chk(!rd_rsp_ready, "R10 no response wait in run", {31'd0, rd_rsp_ready}, 0);
    do_beat(32'h104, "R4 step");
    do_beat(32'h108, "R4 step to boundary");
    do_beat(32'h100, "R4 wrap");
    @(negedge clk);
    chk(ch_addr == 32'h100, "R4 hold without beat", ch_addr, 32'h100);
    pulse_done();
    chk(list_done && busy, "R6 list_done pulse", {30'd0, list_done, busy}, 3);
    @(negedge clk);
    chk(!list_done && !busy, "R6 idle after done", {30'd0, list_done, busy}, 0);
    chk(log_n - b == 4, "R6 no read after done", log_n - b, 4);
  endtask

  task automatic t_chain();
    int b = log_n;
    int d = done_n;
    logic [AW-1:0] bases [3];
    bases[0] = 32'h00; bases[1] = 32'h80; bases[2] = 32'hC0;
    put_desc(32'h00, 32'h200, 32'h20C, 32'h200, 32'h80);
    put_desc(32'h80, 32'h300, 32'h30C, 32'h300, 32'hC0);
    put_desc(32'hC0, 32'h400, 32'h40C, 32'h400, 32'h00);
    bp_en = 1;
    do_start(32'h00);
    for (int j = 0; j < 3; j++) begin
      wait_load("R5 load in chain");
      chk(ch_addr == 32'h200 + 32'h100 * j, "R5 loaded address", ch_addr, 32'h200 + 32'h100 * j);
      chk(log_a[b + 4 * j + 3] == bases[j] + 12, "R5 next descriptor read",
          log_a[b + 4 * j + 3], bases[j] + 12);
      @(negedge clk);
      pulse_done();
      if (j < 2) chk(!list_done, "R6 no early list_done", {31'd0, list_done}, 0);
    end
    chk(list_done, "R6 list_done at return", {31'd0, list_done}, 1);
    @(negedge clk);
    chk(log_n - b == 12 && done_n - d == 1, "R5 twelve reads one done", log_n - b, 12);
    bp_en = 0;
  endtask

  task automatic t_busy_start();
    int b;
    do_start(32'h40);
    wait_load("R7 setup load");
    @(negedge clk);
    b = log_n;
    head_ptr = 32'h80; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(log_n == b && busy, "R7 start ignored while busy", log_n - b, 0);
    chk(ch_addr == 32'h100, "R7 channel unchanged", ch_addr, 32'h100);
    pulse_done();
    chk(list_done, "R7 original chain completes", {31'd0, list_done}, 1);
    @(negedge clk);
  endtask

  task automatic t_rsp_err();
    int b = log_n;
    int l = load_n;
    int d = done_n;
    err_addr = 32'h48;
    do_start(32'h40);
    wait_idle();
    chk(err && !busy, "R8 abort on read error", {30'd0, err, busy}, 2);
    chk(log_n - b == 3, "R8 reads stop at error", log_n - b, 3);
    chk(load_n == l && done_n == d, "R8 no load no done", load_n - l, 0);
    err_addr = 32'hFFFF_FFFF;
    do_start(32'h40);
    chk(!err && busy, "R8 err cleared by start", {30'd0, err, busy}, 1);
    wait_load("R8 restart loads");
    @(negedge clk);
    pulse_done();
    @(negedge clk);
  endtask

  task automatic t_unaligned();
    int b = log_n;
    int l = load_n;
    do_start(32'h42);
    chk(err && !busy, "R9 unaligned head rejected", {30'd0, err, busy}, 2);
    repeat (3) @(negedge clk);
    chk(log_n == b, "R9 no read for bad head", log_n - b, 0);
    put_desc(32'h20, 32'h500, 32'h510, 32'h500, 32'h1A);
    do_start(32'h20);
    wait_idle();
    chk(err && log_n - b == 4, "R9 unaligned next aborts", log_n - b, 4);
    chk(load_n == l, "R9 no load on bad next", load_n - l, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_busy_start();
    t_rsp_err();
    t_unaligned();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule